// File: doc/BRIEF.md
# Length-Prefixed Frame Receiver

This block receives a byte stream cut into transactions by an end-of-transaction strobe. It captures one frame per transaction into an internal byte buffer. A frame opens with a two-byte length header, sent most significant byte first. The header value counts payload bytes only. The block stores the header bytes and the payload next to each other. It then raises `frame_done` and holds the frame length until the transaction closes.

Each new frame starts at a base offset that steps through 0, 1 and 2. This gives software that reads the buffer every byte alignment within a word. A header announcing more than the buffer can hold from that offset is not stored: the receiver sets `oversize` and treats the frame as finished. A consumer reads the buffer through a synchronous read port, using `frame_base` and `frame_len` to find the frame.

The byte input is a valid/ready stream. A byte transfers on a rising clock edge where `in_valid` and `in_ready` are both high. `in_ready` drops for exactly one cycle, right after the second header byte of a frame that fits, while that byte is written. At all other times `in_ready` is high, so the sender never waits longer than one cycle. `in_data` needs to hold steady only while `in_valid` is high and `in_ready` is low.

Top module: `frame_rx`

## Requirements
- R1: `frame_len` is set to `b0*256 + b1 + 2`, where `b0` is the first header byte and `b1` the second. The value is latched when the second header byte transfers.
- R2: A frame that fits is stored with `b0` at address `frame_base`, `b1` next, and payload bytes at the following addresses in arrival order. `rd_data` returns the byte at `rd_addr` one clock after the address is applied.
- R3: Each completed header moves `frame_base` to `(previous + 1) mod 3`, including headers of oversize frames and of frames later aborted. After reset the previous value is 0, so the first frame starts at offset 1.
- R4: If `frame_base + frame_len` exceeds `BUF_BYTES`, the receiver goes straight to the finished state with `oversize` = 1 and writes no byte of that frame. Otherwise `oversize` = 0.
- R5: `frame_done` rises in the cycle after the last byte of the frame transfers. For an empty payload it rises two cycles after the second header byte. It then stays high until an end-of-transaction strobe.
- R6: While `frame_done` is high, bytes are accepted and dropped, and the buffer contents do not change.
- R7: `eot` high while `frame_done` is high clears `frame_done` on the next cycle and readies the receiver for a new header.
- R8: `eot` arriving after zero or one header byte discards that byte. No frame is begun and `frame_base` does not move.
- R9: `eot` while payload is still expected aborts the frame. `frame_done` stays low and the next byte is taken as a new header.
- R10: `frame_len`, `frame_base` and `oversize` do not change from the start of the finished state until the next header completes.
- R11: `in_ready` is low for exactly one cycle, the cycle after the second header byte of a fitting frame, and is high otherwise. When `eot` and a valid byte occur in the same cycle, `eot` takes effect and the byte is dropped.
- R12: After reset `frame_done` = 0, `oversize` = 0 and `in_ready` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Byte on `in_data` is offered |
| in_ready | output | 1 | Receiver takes the offered byte this cycle |
| in_data | input | 8 | Stream byte |
| eot | input | 1 | End-of-transaction strobe, one cycle |
| frame_done | output | 1 | Receiver is in the finished state |
| oversize | output | 1 | Last header announced a frame that did not fit |
| frame_len | output | 17 | Header plus payload byte count of the last header |
| frame_base | output | 2 | Buffer offset of the last frame |
| rd_addr | input | ADDR_W | Buffer read address |
| rd_data | output | 8 | Buffer byte, one cycle after `rd_addr` |

## Verification
The bench builds the block with `BUF_BYTES` = 64 instead of the default 1100. This lets a 62-byte payload fill the buffer exactly from offset 0, and lets the same payload overflow by one byte from offset 1. Both sides of the bounds check are then covered with short frames, and every buffer address can be read back against a shadow copy. A 256-byte header overflows the small buffer by a wide margin, which checks the byte order of the length field. The offset rotation through all three values is covered across empty, short, full, aborted and header-only transactions.

// File: rtl/frame_rx_pkg.sv
package frame_rx_pkg;

  localparam int HDR_W   = 16;
  localparam int LEN_W   = HDR_W + 1;
  localparam int BASE_MOD = 3;
  localparam int BASE_W  = 2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RECV = 2'd1,
    ST_DONE = 2'd2
  } rx_state_e;

  function automatic logic [BASE_W-1:0] step_base(input logic [BASE_W-1:0] cur);
    return (cur == BASE_W'(BASE_MOD - 1)) ? '0 : cur + 1'b1;
  endfunction

endpackage

// File: rtl/frame_rx_mem.sv
module frame_rx_mem #(
  parameter int DEPTH  = 1100,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data
);

  logic [7:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_addr] <= wr_data;
    rd_data <= store[rd_addr];
  end

endmodule

// File: rtl/frame_rx_ctrl.sv
module frame_rx_ctrl
  import frame_rx_pkg::*;
#(
  parameter int BUF_BYTES = 1100,
  parameter int ADDR_W    = $clog2(BUF_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              eot,
  output logic              in_ready,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              frame_done,
  output logic              oversize,
  output logic [LEN_W-1:0]  frame_len,
  output logic [BASE_W-1:0] frame_base
);

  localparam logic [LEN_W:0] CAP = (LEN_W+1)'(BUF_BYTES);

  rx_state_e          state;
  logic               hdr_seen;
  logic               pend;
  logic [7:0]         hdr_b0;
  logic [7:0]         hdr_b1;
  logic [ADDR_W-1:0]  wptr;
  logic [LEN_W-1:0]   remain;
  logic [BASE_W-1:0]  base_r;
  logic [LEN_W-1:0]   len_r;
  logic               ovf_r;

  logic               acc;
  logic [BASE_W-1:0]  nb;
  logic [LEN_W-1:0]   hdr_len;
  logic [LEN_W:0]     need;
  logic               fits;

  always_comb begin
    in_ready = !((state == ST_RECV) && pend);
    acc      = in_valid && in_ready;
    nb       = step_base(base_r);
    hdr_len  = LEN_W'({hdr_b0, in_data}) + LEN_W'(2);
    need     = {1'b0, hdr_len} + (LEN_W+1)'(nb);
    fits     = (need <= CAP);
  end

  always_comb begin
    wr_en   = 1'b0;
    wr_addr = wptr;
    wr_data = in_data;
    if (!eot) begin
      unique case (state)
        ST_IDLE: if (acc && hdr_seen && fits) begin
          wr_en   = 1'b1;
          wr_addr = ADDR_W'(nb);
          wr_data = hdr_b0;
        end
        ST_RECV: if (pend) begin
          wr_en   = 1'b1;
          wr_data = hdr_b1;
        end else if (acc) begin
          wr_en   = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      hdr_seen <= 1'b0;
      pend     <= 1'b0;
      hdr_b0   <= '0;
      hdr_b1   <= '0;
      wptr     <= '0;
      remain   <= '0;
      base_r   <= '0;
      len_r    <= '0;
      ovf_r    <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (eot) begin
            hdr_seen <= 1'b0;
          end else if (acc && !hdr_seen) begin
            hdr_b0   <= in_data;
            hdr_seen <= 1'b1;
          end else if (acc) begin
            hdr_seen <= 1'b0;
            base_r   <= nb;
            len_r    <= hdr_len;
            if (fits) begin
              ovf_r  <= 1'b0;
              hdr_b1 <= in_data;
              pend   <= 1'b1;
              wptr   <= ADDR_W'(nb) + 1'b1;
              remain <= hdr_len - LEN_W'(2);
              state  <= ST_RECV;
            end else begin
              ovf_r  <= 1'b1;
              state  <= ST_DONE;
            end
          end
        end
        ST_RECV: begin
          if (eot) begin
            pend  <= 1'b0;
            state <= ST_IDLE;
          end else if (pend) begin
            pend <= 1'b0;
            wptr <= wptr + 1'b1;
            if (remain == '0) state <= ST_DONE;
          end else if (acc) begin
            wptr   <= wptr + 1'b1;
            remain <= remain - 1'b1;
            if (remain == LEN_W'(1)) state <= ST_DONE;
          end
        end
        ST_DONE: if (eot) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign frame_done = (state == ST_DONE);
  assign oversize   = ovf_r;
  assign frame_len  = len_r;
  assign frame_base = base_r;

endmodule

// File: rtl/frame_rx.sv
module frame_rx
  import frame_rx_pkg::*;
#(
  parameter int BUF_BYTES = 1100,
  localparam int ADDR_W   = $clog2(BUF_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  input  logic              eot,
  output logic              frame_done,
  output logic              oversize,
  output logic [LEN_W-1:0]  frame_len,
  output logic [BASE_W-1:0] frame_base,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data
);

  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [7:0]        wr_data;

  frame_rx_ctrl #(.BUF_BYTES(BUF_BYTES), .ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .eot(eot),
    .in_ready(in_ready), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .frame_done(frame_done), .oversize(oversize), .frame_len(frame_len),
    .frame_base(frame_base)
  );

  frame_rx_mem #(.DEPTH(BUF_BYTES), .ADDR_W(ADDR_W)) mem_i (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

endmodule

// File: rtl/frame_rx_chk.sv
module frame_rx_chk
  import frame_rx_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             in_ready,
  input logic             eot,
  input logic             frame_done,
  input logic             oversize,
  input logic [LEN_W-1:0] frame_len,
  input logic             wr_en
);

  // R10
  len_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && $past(frame_done)) |-> ($stable(frame_len) && $stable(oversize)));

  // R6
  done_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> !wr_en);

  // R7
  eot_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && eot) |=> !frame_done);

  // R5
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !eot) |=> frame_done);

  // R11
  ready_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> in_ready);

  // R4
  ovf_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oversize) |-> !$past(wr_en));

endmodule

bind frame_rx frame_rx_chk chk_i (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .eot(eot),
  .frame_done(frame_done), .oversize(oversize), .frame_len(frame_len),
  .wr_en(wr_en)
);

// File: tb/frame_rx_tb_top.sv
module frame_rx_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int BUF = 64;
  localparam int AW = $clog2(BUF);

  logic clk = 0, rst_n = 0, in_valid = 0, eot = 0;
  logic [7:0] in_data = 0;
  logic [AW-1:0] rd_addr = 0;
  logic in_ready, frame_done, oversize;
  logic [16:0] frame_len;
  logic [1:0] frame_base;
  logic [7:0] rd_data;

  int total = 0, bad = 0, base_m = 0, stalls = 0;
  bit finished = 0;
  logic [7:0] shadow [BUF];
  typedef struct { int addr; logic [7:0] data; } item_t;
  item_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_rx #(.BUF_BYTES(BUF)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .eot(eot), .frame_done(frame_done), .oversize(oversize),
    .frame_len(frame_len), .frame_base(frame_base), .rd_addr(rd_addr),
    .rd_data(rd_data));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push_byte(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1; in_data = b;
    while (!in_ready) begin stalls++; @(negedge clk); end
    @(posedge clk);
  endtask

  task automatic idle(input int n);
    @(negedge clk); in_valid = 0;
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_eot(input bit with_byte, input logic [7:0] b);
    @(negedge clk);
    in_valid = with_byte; in_data = b; eot = 1;
    @(negedge clk);
    in_valid = 0; eot = 0;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    @(negedge clk); rd_addr = AW'(a);
    @(negedge clk); d = rd_data;
  endtask

  // driver: sends header, payload (or 'extra' bytes if oversize) and records expectations
  task automatic send_frame(input int plen, input logic [7:0] seed, input int extra);
    int b, len; bit fits;
    logic [7:0] v;
    b = (base_m + 1) % 3; base_m = b; len = plen + 2;
    fits = (b + len) <= BUF;
    stalls = 0;
    push_byte(8'(plen >> 8));
    push_byte(8'(plen));
    if (fits) begin
      exp_q.push_back('{b, 8'(plen >> 8)}); shadow[b] = 8'(plen >> 8);
      exp_q.push_back('{b+1, 8'(plen)});    shadow[b+1] = 8'(plen);
    end
    for (int i = 0; i < (fits ? plen : extra); i++) begin
      v = 8'(i) ^ seed;
      push_byte(v);
      if (fits) begin exp_q.push_back('{b+2+i, v}); shadow[b+2+i] = v; end
    end
    idle(2);
  endtask

  // monitor: pops expected bytes and compares buffer contents
  task automatic drain_check(input string req);
    logic [7:0] d;
    item_t it;
    while (exp_q.size() > 0) begin
      it = exp_q.pop_front();
      rd(it.addr, d);
      chk(req, 32'(d), 32'(it.data));
    end
  endtask

  task automatic shadow_check(input string req);
    logic [7:0] d;
    for (int a = 0; a < BUF; a++) begin
      rd(a, d);
      if (shadow[a] !== 8'hxx) chk(req, 32'(d), 32'(shadow[a]));
    end
  endtask

  initial begin
    logic [7:0] d6a, d6b;
    for (int a = 0; a < BUF; a++) shadow[a] = 8'hxx;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12 reset state
    chk("R12 done", 32'(frame_done), 0);
    chk("R12 oversize", 32'(oversize), 0);
    chk("R12 ready", 32'(in_ready), 1);

    // R1 R2 R5 R3: 3-byte payload at base 1
    send_frame(3, 8'hA1, 0);
    chk("R5 done", 32'(frame_done), 1);
    chk("R1 len", 32'(frame_len), 5);
    chk("R3 base", 32'(frame_base), 1);
    chk("R11 stall", 32'(stalls), 1);
    drain_check("R2 data");
    // R6 trailing bytes ignored
    rd(6, d6a);
    push_byte(8'h55); push_byte(8'h66); idle(1);
    rd(6, d6b);
    chk("R6 addr6", 32'(d6b), 32'(d6a));
    chk("R6 done", 32'(frame_done), 1);
    chk("R10 len", 32'(frame_len), 5);
    shadow_check("R6 buffer");
    // R7
    pulse_eot(0, 0);
    chk("R7 exit", 32'(frame_done), 0);

    // R5 empty payload, base 2
    send_frame(0, 8'h00, 0);
    chk("R5 empty done", 32'(frame_done), 1);
    chk("R1 empty len", 32'(frame_len), 2);
    chk("R3 base2", 32'(frame_base), 2);
    drain_check("R2 empty");
    pulse_eot(0, 0);

    // R4 exact fit at base 0
    send_frame(62, 8'h5A, 0);
    chk("R4 fit ovf", 32'(oversize), 0);
    chk("R4 fit len", 32'(frame_len), 64);
    chk("R3 base0", 32'(frame_base), 0);
    drain_check("R2 full");
    pulse_eot(0, 0);

    // R4 one byte over at base 1
    send_frame(62, 8'h33, 3);
    chk("R4 ovf", 32'(oversize), 1);
    chk("R4 ovf done", 32'(frame_done), 1);
    chk("R4 ovf stall", 32'(stalls), 0);
    shadow_check("R4 untouched");
    pulse_eot(0, 0);
    chk("R10 ovf held", 32'(oversize), 1);

    // R1 big-endian header 01 00
    send_frame(256, 8'h00, 0);
    chk("R1 be len", 32'(frame_len), 258);
    chk("R1 be ovf", 32'(oversize), 1);
    pulse_eot(0, 0);

    // R8 single header byte then eot
    push_byte(8'h07); idle(0);
    pulse_eot(0, 0);
    chk("R8 no frame", 32'(frame_done), 0);
    send_frame(1, 8'h99, 0);
    chk("R8 base kept", 32'(frame_base), 0);
    chk("R8 len", 32'(frame_len), 3);
    drain_check("R8 data");
    pulse_eot(0, 0);

    // R9 abort mid payload
    push_byte(8'h00); push_byte(8'h04); push_byte(8'hEE); idle(0);
    pulse_eot(0, 0);
    base_m = (base_m + 1) % 3;
    idle(1);
    chk("R9 aborted", 32'(frame_done), 0);
    send_frame(2, 8'hC0, 0);
    chk("R9 base", 32'(frame_base), 2);
    chk("R9 len", 32'(frame_len), 4);
    drain_check("R9 data");

    // R11 eot with a byte in the same cycle: byte dropped
    pulse_eot(1, 8'h01);
    send_frame(1, 8'h77, 0);
    chk("R11 eot wins len", 32'(frame_len), 3);
    chk("R11 eot wins ovf", 32'(oversize), 0);
    drain_check("R11 data");
    shadow_check("R2 final");

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule